// File: doc/BRIEF.md
# Touch Sample FIFO with Interrupts

This block is the register-facing back end of a resistive touch controller. A scan engine hands it averaged X/Y coordinate pairs and a debounced pen-down level. The coordinate pairs go into a 32-entry FIFO. The block raises a level interrupt for three causes, and the host can mask each one. The first cause is the FIFO count reaching a programmable threshold. The second is any change of pen state. The third is a sample dropped because the FIFO was full.

A host talks to the block through a simple register port with read and write strobes, a byte address and 32-bit data. Through it the host sets the threshold and the mask, reads the status and clears it by writing ones, reads the live pen state, and pops samples. Read data is combinational from the address. A read of the data register pops one entry at the clock edge that ends the read cycle. When the FIFO is empty, that read returns an all-ones word.

Top module: `touch_fifo_irq`

## Requirements
- R1: After reset, status, mask and threshold read 0, `irq_o` is low, the pen state reads 0 and the FIFO is empty.
- R2: A FIFO word holds X left-aligned in bits [15:4] and Y left-aligned in bits [31:20]. Bits [3:0] and [19:16] are zero.
- R3: A read of the data register (0x18) while the FIFO is empty returns 0xFFFFFFFF. It changes no state.
- R4: A read of 0x18 while the FIFO holds data returns the oldest entry and pops it at that clock edge. Entries come out in push order.
- R5: The FIFO holds 32 entries. A push while it is full, with no pop in the same cycle, drops the new sample and sets sticky status bit 3.
- R6: With threshold T in 1..31 (register 0x08, bits [4:0]), status bit 2 sets one cycle after the stored count becomes at least T. With T = 0, bit 2 never sets.
- R7: Status bit 0 sets on every change of `pen_down_i`, both press and release. Bit 0 of register 0x14 shows the registered pen level.
- R8: Status (0x10) is write-1-to-clear. A written 0 leaves its bit unchanged. A cause present in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some status bit is set and its mask bit (register 0x0C, bits 0, 2 and 3) is set.
- R10: The threshold and mask registers read back the values written, with unused bits reading 0.
- R11: Addresses other than 0x08, 0x0C, 0x10, 0x14 and 0x18 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Push strobe for one coordinate pair |
| sample_x_i | input | 12 | X coordinate |
| sample_y_i | input | 12 | Y coordinate |
| pen_down_i | input | 1 | Debounced pen-down level |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume one register access per cycle, with read and write never asserted together. They assume `pen_down_i` is already debounced and synchronous, so any difference from the registered level is a real event. They also assume that a write to the data register is not used as a pop. The bench drives every input at the falling edge and opens each read or write strobe for exactly one cycle. It holds the pen level steady between deliberate transitions, and it pushes and pops only through the defined strobes.

// File: rtl/touch_fifo_pkg.sv
package touch_fifo_pkg;
  localparam logic [7:0] OFS_THR  = 8'h08;
  localparam logic [7:0] OFS_MASK = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_CTRL = 8'h14;
  localparam logic [7:0] OFS_DATA = 8'h18;

  localparam int unsigned BIT_PEN = 0;
  localparam int unsigned BIT_THR = 2;
  localparam int unsigned BIT_OVF = 3;
  localparam int unsigned STAT_W  = 4;

  localparam logic [STAT_W-1:0] STAT_IMPL = 4'b1101;
  localparam logic [31:0]       EMPTY_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/tf_sample_fifo.sv
module tf_sample_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && !do_push;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tf_irq_ctrl.sv
module tf_irq_ctrl import touch_fifo_pkg::*; #(
  parameter int CNT_W = 6,
  parameter int THR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pen_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              drop_i,
  input  logic              clr_en_i,
  input  logic [STAT_W-1:0] clr_bits_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              pen_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, set_v, clr_v;
  logic              pen_q;

  always_comb begin
    set_v          = '0;
    set_v[BIT_PEN] = (pen_i != pen_q);
    set_v[BIT_THR] = (thr_i != '0) && (count_i >= CNT_W'(thr_i));
    set_v[BIT_OVF] = drop_i;
    clr_v          = clr_en_i ? clr_bits_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      pen_q  <= 1'b0;
    end else begin
      // set wins over a simultaneous clear
      stat_q <= ((stat_q & ~clr_v) | set_v) & STAT_IMPL;
      pen_q  <= pen_i;
    end
  end

  assign status_o = stat_q;
  assign pen_o    = pen_q;
  assign irq_o    = |(stat_q & mask_i);
endmodule

// File: rtl/tf_reg_port.sv
module tf_reg_port import touch_fifo_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 12,
  parameter int THR_W   = 5,
  localparam int HALF_W = DATA_W / 2,
  localparam int PAD_W  = HALF_W - COORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [STAT_W-1:0]    status_i,
  input  logic                 pen_i,
  input  logic [2*COORD_W-1:0] fifo_data_i,
  input  logic                 fifo_empty_i,
  output logic                 pop_o,
  output logic                 clr_en_o,
  output logic [STAT_W-1:0]    clr_bits_o,
  output logic [THR_W-1:0]     thr_o,
  output logic [STAT_W-1:0]    mask_o
);
  logic [THR_W-1:0]  thr_q;
  logic [STAT_W-1:0] mask_q;
  logic [COORD_W-1:0] fx, fy;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(OFS_THR))  thr_q  <= wdata_i[THR_W-1:0];
      if (addr_i == ADDR_W'(OFS_MASK)) mask_q <= wdata_i[STAT_W-1:0] & STAT_IMPL;
    end
  end

  assign pop_o      = rd_i && (addr_i == ADDR_W'(OFS_DATA));
  assign clr_en_o   = wr_i && (addr_i == ADDR_W'(OFS_STAT));
  assign clr_bits_o = wdata_i[STAT_W-1:0];
  assign thr_o      = thr_q;
  assign mask_o     = mask_q;
  assign fx         = fifo_data_i[COORD_W-1:0];
  assign fy         = fifo_data_i[2*COORD_W-1:COORD_W];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_THR):  rdata_o = DATA_W'(thr_q);
      ADDR_W'(OFS_MASK): rdata_o = DATA_W'(mask_q);
      ADDR_W'(OFS_STAT): rdata_o = DATA_W'(status_i);
      ADDR_W'(OFS_CTRL): rdata_o = DATA_W'(pen_i);
      ADDR_W'(OFS_DATA): begin
        if (fifo_empty_i) rdata_o = DATA_W'(EMPTY_WORD);
        else              rdata_o = {fy, {PAD_W{1'b0}}, fx, {PAD_W{1'b0}}};
      end
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/touch_fifo_irq.sv
module touch_fifo_irq import touch_fifo_pkg::*; #(
  parameter int DEPTH   = 32,
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [COORD_W-1:0] sample_x_i,
  input  logic [COORD_W-1:0] sample_y_i,
  input  logic               pen_down_i,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int THR_W = $clog2(DEPTH);
  localparam int ENT_W = 2 * COORD_W;

  logic [ENT_W-1:0]  fifo_rdata;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_full, fifo_empty, fifo_drop, fifo_pop;
  logic [STAT_W-1:0] status, mask, clr_bits;
  logic              clr_en, pen_state;
  logic [THR_W-1:0]  cfg_thr;

  tf_sample_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sample_valid_i),
    .wdata_i ({sample_y_i, sample_x_i}),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .count_o (fifo_count),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  tf_irq_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pen_i      (pen_down_i),
    .count_i    (fifo_count),
    .thr_i      (cfg_thr),
    .drop_i     (fifo_drop),
    .clr_en_i   (clr_en),
    .clr_bits_i (clr_bits),
    .mask_i     (mask),
    .status_o   (status),
    .pen_o      (pen_state),
    .irq_o      (irq_o)
  );

  tf_reg_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COORD_W(COORD_W), .THR_W(THR_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (reg_rd_i),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .status_i     (status),
    .pen_i        (pen_state),
    .fifo_data_i  (fifo_rdata),
    .fifo_empty_i (fifo_empty),
    .pop_o        (fifo_pop),
    .clr_en_o     (clr_en),
    .clr_bits_o   (clr_bits),
    .thr_o        (cfg_thr),
    .mask_o       (mask)
  );
endmodule

// File: rtl/touch_fifo_irq_chk.sv
module touch_fifo_irq_chk import touch_fifo_pkg::*; #(
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 6,
  parameter int THR_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic              pen_down_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [CNT_W-1:0]  count,
  input logic              full,
  input logic              empty,
  input logic [STAT_W-1:0] status,
  input logic [THR_W-1:0]  thr,
  input logic              pen_state
);
  logic data_rd, stat_wr;
  assign data_rd = reg_rd_i && (reg_addr_i == ADDR_W'(OFS_DATA));
  assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STAT));

  // R3
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && empty) |-> (reg_rdata_o == DATA_W'(EMPTY_WORD)));

  // R4
  pop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !empty && !sample_valid_i) |=> (count == $past(count) - 1'b1));

  // R5
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  // R5
  overflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && full && !data_rd) |=> status[BIT_OVF]);

  // R6
  thr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((thr != '0) && (count >= CNT_W'(thr))) |=> status[BIT_THR]);

  // R7
  pen_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pen_down_i != pen_state) |=> (status[BIT_PEN] && (pen_state == $past(pen_down_i))));

  // R8
  thr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status[BIT_THR]) |-> $past(stat_wr && reg_wdata_i[BIT_THR]));
endmodule

bind touch_fifo_irq touch_fifo_irq_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .pen_down_i     (pen_down_i),
  .reg_rd_i       (reg_rd_i),
  .reg_wr_i       (reg_wr_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .count          (fifo_count),
  .full           (fifo_full),
  .empty          (fifo_empty),
  .status         (status),
  .thr            (cfg_thr),
  .pen_state      (pen_state)
);

// File: tb/touch_fifo_irq_tb.sv
`timescale 1ns/1ps
module touch_fifo_irq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [11:0] sample_x_i = '0, sample_y_i = '0;
  logic        pen_down_i = 1'b0;
  logic        reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  touch_fifo_irq u_dut (.*);

  localparam logic [7:0] A_THR = 8'h08, A_MASK = 8'h0C, A_STAT = 8'h10,
                         A_CTRL = 8'h14, A_DATA = 8'h18;

  // {x, y} pairs
  localparam logic [23:0] VEC [8] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h123, 12'h456},
    {12'hA5A, 12'h5A5}, {12'h001, 12'h800}, {12'h7FF, 12'h001},
    {12'hC3C, 12'h3C3}, {12'h0F0, 12'hF0F}};

  function automatic logic [31:0] word(input logic [11:0] x, input logic [11:0] y);
    return {y, 4'h0, x, 4'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(posedge clk_i); #1 reg_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1 reg_wr_i = 1'b0;
  endtask

  task automatic push(input logic [11:0] x, input logic [11:0] y);
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_x_i = x; sample_y_i = y;
    @(posedge clk_i); #1 sample_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_MASK, d); check("R1 mask", d, 32'h0);
    rd(A_THR, d);  check("R1 thr", d, 32'h0);
    rd(A_CTRL, d); check("R1 pen", d, 32'h0);
    rd(A_DATA, d); check("R3 empty after reset", d, 32'hFFFF_FFFF);

    // R10 readback
    wr(A_THR, 32'hFFFF_FFE3); rd(A_THR, d); check("R10 thr", d, 32'h03);
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, d); check("R10 mask", d, 32'h0D);

    // R2 R4 R6 table walk
    foreach (VEC[i]) push(VEC[i][23:12], VEC[i][11:0]);
    idle(2);
    rd(A_STAT, d); check("R6 thr flag at 8>=3", d, 32'h4);
    check("R9 irq on thr", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h0); rd(A_STAT, d); check("R8 write 0 keeps", d, 32'h4);
    wr(A_STAT, 32'h4); idle(1); rd(A_STAT, d); check("R8 cause wins", d, 32'h4);
    foreach (VEC[i]) begin
      rd(A_DATA, d);
      check($sformatf("R2 R4 entry %0d", i), d, word(VEC[i][23:12], VEC[i][11:0]));
    end
    rd(A_DATA, d); check("R3 drained", d, 32'hFFFF_FFFF);
    rd(A_DATA, d); check("R3 no state change", d, 32'hFFFF_FFFF);
    wr(A_STAT, 32'h4); idle(1); rd(A_STAT, d); check("R8 clear", d, 32'h0);
    check("R9 irq low", {31'b0, irq_o}, 32'h0);

    // R6 boundary T=5
    wr(A_THR, 32'd5);
    for (int i = 0; i < 4; i++) push(12'(i), 12'(i));
    idle(2); rd(A_STAT, d); check("R6 below thr", d, 32'h0);
    push(12'h4, 12'h4);
    idle(2); rd(A_STAT, d); check("R6 at thr", d, 32'h4);
    for (int i = 0; i < 5; i++) rd(A_DATA, d);
    check("R4 last of five", d, word(12'h4, 12'h4));
    wr(A_STAT, 32'h4);

    // R6 threshold zero disables
    wr(A_THR, 32'd0);
    push(12'h111, 12'h222); push(12'h333, 12'h444);
    idle(2); rd(A_STAT, d); check("R6 thr zero", d, 32'h0);
    rd(A_DATA, d); rd(A_DATA, d); check("R4 second", d, word(12'h333, 12'h444));

    // R7 pen events
    @(negedge clk_i) pen_down_i = 1'b1;
    idle(1);
    rd(A_CTRL, d); check("R7 pen level down", d, 32'h1);
    rd(A_STAT, d); check("R7 press flag", d, 32'h1);
    check("R9 irq on pen", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h1); idle(1); rd(A_STAT, d); check("R8 pen clear", d, 32'h0);
    @(negedge clk_i) pen_down_i = 1'b0;
    idle(1);
    rd(A_STAT, d); check("R7 release flag", d, 32'h1);
    rd(A_CTRL, d); check("R7 pen level up", d, 32'h0);
    wr(A_MASK, 32'h4); idle(1);
    check("R9 masked pen", {31'b0, irq_o}, 32'h0);
    wr(A_STAT, 32'h1);

    // R5 overflow
    for (int i = 0; i < 33; i++) push(12'(i * 7 + 1), 12'(4095 - i));
    idle(2);
    rd(A_STAT, d); check("R5 overflow flag", d, 32'h8);
    wr(A_MASK, 32'h8); idle(1);
    check("R9 irq on overflow", {31'b0, irq_o}, 32'h1);
    for (int i = 0; i < 32; i++) begin
      rd(A_DATA, d);
      check($sformatf("R5 kept entry %0d", i), d, word(12'(i * 7 + 1), 12'(4095 - i)));
    end
    rd(A_DATA, d); check("R5 33rd dropped", d, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R5 sticky", d, 32'h8);
    wr(A_STAT, 32'h8); idle(1); rd(A_STAT, d); check("R8 overflow clear", d, 32'h0);

    // R11 unmapped
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R11 unmapped read", d, 32'h0);
    rd(8'h00, d); check("R11 addr 0 read", d, 32'h0);
    rd(A_THR, d); check("R11 thr untouched", d, 32'h0);
    rd(A_MASK, d); check("R11 mask untouched", d, 32'h8);
    rd(A_STAT, d); check("R11 status untouched", d, 32'h0);

    finish_run();
  end
endmodule